// File: doc/BRIEF.md
# Interrupt Request Latch with Default Report

This block collects a set of asynchronous interrupt request lines, raises a single interrupt output toward the processor, and answers each acknowledge with a vector. The vector is a programmable base plus the number of the winning line. Each general line can be set to react to a rising edge or to a high level. Two lines are fixed in edge mode whatever software writes: line 1 reacts to a rising transition, and line 8 reacts to a falling transition of its pin because that line is active-low.

Priority is fixed, and line 0 is the most urgent. A line that is acknowledged leaves the pending set and enters the in-service set, where it stays until an end-of-interrupt command. While it is in service it holds back every line of equal or lower urgency. Sometimes a request is withdrawn before the acknowledge arrives, or nothing unmasked is pending when the acknowledge comes. In either case the block reports the default line 7 and marks nothing as in service.

Top module: `irq_latch`

## Requirements
- R1: While reset is high, and on the first cycle after it, `intr` and `ack_valid` are 0. After reset every line is in edge mode, no line is masked, nothing is in service and the vector base is 0x20.
- R2: Raw request inputs pass through a two-flop synchronizer. A request therefore cannot reach `intr` in the cycle in which it is applied.
- R3: In edge mode (mode bit 0) a line latches a request on a low-to-high transition of its active level. A line held active after it has been acknowledged and closed with an end-of-interrupt does not request again.
- R4: In level mode (mode bit 1) a line requests for as long as it is active. After an end-of-interrupt it raises `intr` again if it is still high.
- R5: Line 1 is always edge-triggered. Its mode bit is ignored.
- R6: Line 8 is active-low and always edge-triggered. A falling pin latches a request. A rising pin, or a pin held low, does not.
- R7: If no unmasked request is active when `inta` is sampled, the response is base + 7. This covers an edge request that was withdrawn before the acknowledge. No in-service bit is set in this case.
- R8: At acknowledge, the lowest-numbered active unmasked line wins. Exactly that one line becomes in service.
- R9: A line whose mask bit is 1 neither raises `intr` nor wins an acknowledge. Its edge latch persists while its input stays active.
- R10: `intr` is 1 only when some active unmasked line is numbered below every line that is in service.
- R11: `ack_valid` is 1 for exactly the cycle after `inta` is sampled high. `ack_vector` is the base register plus the line number.
- R12: `eoi` clears the in-service bit of the lowest-numbered line that is in service.
- R13: Configuration is written with `cfg_we`, selected by `cfg_sel`: 0 writes the mode bits, 1 writes the mask bits, 2 writes the base from `cfg_wdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Raw asynchronous request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 mask, 2 base |
| cfg_wdata | input | 16 | Configuration write data |
| inta | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| eoi | input | 1 | End-of-interrupt command |
| intr | output | 1 | Registered interrupt output to the processor |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vector | output | 8 | Base plus winning line number |

## Verification
The bench withdraws an edge request before acknowledging it and expects vector 0x27. It then checks that a line 9 request is still let through. A design that marked line 7 in service would block that line 9 request. It also writes level mode to line 1 and holds line 8 low after its acknowledge and end-of-interrupt. A block that honoured the mode bit or the pin level would raise `intr` again. The nesting test has line 2 in service above line 5 and checks that the end-of-interrupt clears line 2. It then checks that a new line 4 request gets through. A design that cleared the wrong bit would leave line 4 blocked by line 2. The bench also checks that a masked line loses to a lower-priority unmasked one, and that its latch survives unmasking.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic [1:0] {
    CFG_MODE = 2'd0,
    CFG_MASK = 2'd1,
    CFG_BASE = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 16,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int N = 16,
  parameter logic [N-1:0] FIXED_EDGE = '0,
  parameter logic [N-1:0] ACT_LOW = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sync_in,
  input  logic [N-1:0] level_mode,
  input  logic [N-1:0] clr_lat,
  output logic [N-1:0] req
);
  logic [N-1:0] act, act_d, lat, level_eff;

  assign act = sync_in ^ ACT_LOW;

  for (genvar i = 0; i < N; i++) begin : g_line
    if (FIXED_EDGE[i]) begin : g_fixed
      assign level_eff[i] = 1'b0;
      // R5 R6: a fixed-edge line held active and idle stays idle
      fixed_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (act[i] && act_d[i] && !req[i] && !clr_lat[i]) |=> !req[i]);
    end else begin : g_prog
      assign level_eff[i] = level_mode[i];
    end
    assign req[i] = level_eff[i] ? act[i] : (lat[i] & act[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_d <= '0;
      lat   <= '0;
    end else begin
      act_d <= act;
      lat   <= act & (lat | ~act_d) & ~clr_lat;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N = 16,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [LW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = i[LW-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch
  import irq_latch_pkg::*;
#(
  parameter int N = 16,
  parameter int VEC_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEFAULT_LINE = 7,
  parameter logic [VEC_W-1:0] BASE_RST = 8'h20,
  parameter logic [N-1:0] FIXED_EDGE = 16'h0102,
  parameter logic [N-1:0] ACT_LOW = 16'h0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     irq_in,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [N-1:0]     cfg_wdata,
  input  logic             inta,
  input  logic             eoi,
  output logic             intr,
  output logic             ack_valid,
  output logic [VEC_W-1:0] ack_vector
);
  localparam int LW = $clog2(N);
  localparam logic [LW-1:0] DEF_IDX = LW'(DEFAULT_LINE);

  logic [N-1:0] sync_q, req, cand, clr_lat, isr_q, eoi_clr, isr_set;
  logic [N-1:0] mode_r, mask_r;
  logic [VEC_W-1:0] base_r;
  logic c_found, i_found, intr_next;
  logic [LW-1:0] c_idx, i_idx, line_sel;

  irq_sync #(.W(N), .STAGES(SYNC_STAGES), .RST_VAL(ACT_LOW)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(sync_q)
  );

  irq_detect #(.N(N), .FIXED_EDGE(FIXED_EDGE), .ACT_LOW(ACT_LOW)) u_detect (
    .clk(clk), .rst(rst), .sync_in(sync_q), .level_mode(mode_r),
    .clr_lat(clr_lat), .req(req)
  );

  assign cand = req & ~mask_r;

  irq_prio #(.N(N)) u_prio_req (.vec(cand),  .found(c_found), .idx(c_idx));
  irq_prio #(.N(N)) u_prio_isr (.vec(isr_q), .found(i_found), .idx(i_idx));

  assign intr_next = c_found && !(i_found && (i_idx <= c_idx));
  assign line_sel  = c_found ? c_idx : DEF_IDX;
  assign isr_set   = (inta && c_found) ? (N'(1) << c_idx) : '0;
  assign clr_lat   = isr_set;
  assign eoi_clr   = (eoi && i_found) ? (N'(1) << i_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= '0;
      mask_r <= '0;
      base_r <= BASE_RST;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_MODE: mode_r <= cfg_wdata;
        CFG_MASK: mask_r <= cfg_wdata;
        CFG_BASE: base_r <= cfg_wdata[VEC_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q      <= '0;
      intr       <= 1'b0;
      ack_valid  <= 1'b0;
      ack_vector <= '0;
    end else begin
      isr_q     <= (isr_q & ~eoi_clr) | isr_set;
      intr      <= intr_next;
      ack_valid <= inta;
      if (inta) ack_vector <= base_r + {{(VEC_W-LW){1'b0}}, line_sel};
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!intr && !ack_valid));
  // R11
  ack_follows_inta_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(inta));
  // R9
  masked_intr_chk: assert property (@(posedge clk) disable iff (rst)
    intr |-> $past(|(req & ~mask_r)));
  // R8
  isr_single_set_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(isr_q & ~$past(isr_q)));
  // R12
  eoi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi && !inta && (|isr_q)) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
endmodule

// File: tb/test_irq_latch.sv
module test_irq_latch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] irq_in = 16'h0100;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic inta = 1'b0;
  logic eoi = 1'b0;
  logic intr, ack_valid;
  logic [7:0] ack_vector;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_latch i_irq_latch (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .inta(inta), .eoi(eoi), .intr(intr),
    .ack_valid(ack_valid), .ack_vector(ack_vector)
  );

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_ack(input int exp, input string tag);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    check(ack_valid, 1, {tag, " valid"});
    check(ack_vector, exp, {tag, " vector"});
    @(negedge clk);
    check(ack_valid, 0, {tag, " valid drop"});
  endtask

  task automatic do_eoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  task automatic t_reset();
    check(intr, 0, "R1 intr in reset");
    check(ack_valid, 0, "R1 ack_valid in reset");
    @(negedge clk); rst = 1'b0;
    check(intr, 0, "R1 intr after reset");
    wait_cyc(4);
    check(intr, 0, "R1 idle intr");
  endtask

  task automatic t_edge();
    @(negedge clk); irq_in[4] = 1'b1;
    @(negedge clk);
    check(intr, 0, "R2 no same-cycle intr");
    wait_cyc(6);
    check(intr, 1, "R3 edge raises intr");
    do_ack(8'h24, "R11 edge ack");
    wait_cyc(3);
    check(intr, 0, "R10 in-service blocks own line");
    do_eoi();
    wait_cyc(4);
    check(intr, 0, "R3 held edge no retrigger");
    irq_in[4] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_level();
    cfg_write(2'd0, 16'h0020);
    @(negedge clk); irq_in[5] = 1'b1;
    wait_cyc(6);
    check(intr, 1, "R4 level raises intr");
    do_ack(8'h25, "R4 level ack");
    wait_cyc(3);
    check(intr, 0, "R4 blocked while in service");
    do_eoi();
    wait_cyc(4);
    check(intr, 1, "R4 level retrigger after eoi");
    irq_in[5] = 1'b0;
    wait_cyc(5);
    check(intr, 0, "R4 level drop clears intr");
    cfg_write(2'd0, 16'h0000);
  endtask

  task automatic t_line1();
    cfg_write(2'd0, 16'h0002);
    @(negedge clk); irq_in[1] = 1'b1;
    wait_cyc(6);
    check(intr, 1, "R5 line1 request");
    do_ack(8'h21, "R5 line1 ack");
    do_eoi();
    wait_cyc(4);
    check(intr, 0, "R5 line1 mode bit ignored");
    irq_in[1] = 1'b0;
    cfg_write(2'd0, 16'h0000);
    wait_cyc(4);
  endtask

  task automatic t_line8();
    cfg_write(2'd0, 16'h0100);
    @(negedge clk); irq_in[8] = 1'b0;
    wait_cyc(6);
    check(intr, 1, "R6 line8 falling request");
    do_ack(8'h28, "R6 line8 ack");
    do_eoi();
    wait_cyc(4);
    check(intr, 0, "R6 line8 held low no retrigger");
    irq_in[8] = 1'b1;
    wait_cyc(6);
    check(intr, 0, "R6 line8 rising pin no request");
    cfg_write(2'd0, 16'h0000);
  endtask

  task automatic t_spurious();
    @(negedge clk); irq_in[3] = 1'b1;
    wait_cyc(6);
    check(intr, 1, "R7 line3 pending");
    irq_in[3] = 1'b0;
    wait_cyc(6);
    check(intr, 0, "R7 withdrawn drops intr");
    do_ack(8'h27, "R7 default report");
    @(negedge clk); irq_in[9] = 1'b1;
    wait_cyc(6);
    check(intr, 1, "R7 default sets no in-service");
    do_ack(8'h29, "R7 line9 ack");
    do_eoi();
    irq_in[9] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_prio();
    @(negedge clk); irq_in[6] = 1'b1; irq_in[3] = 1'b1;
    wait_cyc(6);
    do_ack(8'h23, "R8 lowest line wins");
    wait_cyc(3);
    check(intr, 0, "R10 line3 blocks line6");
    do_eoi();
    wait_cyc(4);
    check(intr, 1, "R8 line6 after eoi");
    do_ack(8'h26, "R8 second winner");
    do_eoi();
    irq_in[6] = 1'b0; irq_in[3] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_mask();
    cfg_write(2'd1, 16'h0004);
    @(negedge clk); irq_in[2] = 1'b1;
    wait_cyc(6);
    check(intr, 0, "R9 masked line no intr");
    do_ack(8'h27, "R9 masked line cannot win");
    @(negedge clk); irq_in[10] = 1'b1;
    wait_cyc(6);
    check(intr, 1, "R9 unmasked line10 intr");
    do_ack(8'h2A, "R9 line10 beats masked line2");
    do_eoi();
    cfg_write(2'd1, 16'h0000);
    wait_cyc(4);
    check(intr, 1, "R9 latch kept while masked");
    do_ack(8'h22, "R9 line2 after unmask");
    do_eoi();
    irq_in[2] = 1'b0; irq_in[10] = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_nest();
    @(negedge clk); irq_in[5] = 1'b1;
    wait_cyc(6);
    do_ack(8'h25, "R10 line5 ack");
    @(negedge clk); irq_in[9] = 1'b1;
    wait_cyc(6);
    check(intr, 0, "R10 line9 blocked by line5");
    @(negedge clk); irq_in[2] = 1'b1;
    wait_cyc(6);
    check(intr, 1, "R10 line2 nests over line5");
    do_ack(8'h22, "R10 nested ack");
    do_eoi();
    wait_cyc(3);
    @(negedge clk); irq_in[4] = 1'b1;
    wait_cyc(6);
    check(intr, 1, "R12 eoi cleared line2 not line5");
    do_ack(8'h24, "R12 line4 ack");
    do_eoi();
    do_eoi();
    wait_cyc(4);
    check(intr, 1, "R12 line9 after all eoi");
    do_ack(8'h29, "R12 line9 ack");
    do_eoi();
    irq_in = 16'h0100;
    wait_cyc(4);
  endtask

  task automatic t_base();
    cfg_write(2'd2, 16'h0040);
    @(negedge clk); irq_in[11] = 1'b1;
    wait_cyc(6);
    do_ack(8'h4B, "R13 R11 new base");
    do_eoi();
    irq_in[11] = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    wait_cyc(2);
    t_reset();
    t_edge();
    t_level();
    t_line1();
    t_line8();
    t_spurious();
    t_prio();
    t_mask();
    t_nest();
    t_base();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule